// File: doc/BRIEF.md
# Retention Standby Sequencer

This block moves a design into and out of a very-low-power retention state. An active-low request pin, passed through a two-flop synchronizer, starts the entry. The block then raises a set of retention controls: a register hold enable, a gate on the clock input pads, a force-high on every pad-to-core input, a freeze on general-purpose output data and enables, a pull-down request for double-data-rate outputs, and a reset for the clock-management units. Both transitions are timed by a microsecond prescaler that runs on a free-running reference clock.

When the request is released, the block lets the clock-management units out of reset and runs the exit window. It holds every other retention control, and the status flag, until the window has elapsed and the PLL reports lock. If lock does not come within a set limit after the window, a timeout flag is raised. A transition that has started always runs to its end. The state itself has four values: normal, entering, standby and exiting.

Top module: `stby_seq`

## Requirements
- R1: `stby_req_n` is active low (0 requests standby, 1 selects normal operation) and passes through two synchronizer flops. A falling request seen at clock edge k makes `stby_status` high after edge k+2.
- R2: The entry phase lasts exactly WINDOW_US*CYC_PER_US reference clocks. `cmu_reset` is high for the whole of the entry phase and the standby phase.
- R3: `hold_en`, `in_force`, `out_freeze` and `ddr_pulldown` are high, and `clk_pad_en` is low, from the first entry cycle until the block is back in normal operation. In normal operation they hold the opposite values.
- R4: While `in_force` is high, every bit of `core_in` is 1 whatever `pad_in` carries. Otherwise `core_in` equals `pad_in`.
- R5: While frozen, `pad_out` and `pad_oe` keep the `core_out` and `core_oe` values sampled at the last clock edge of normal operation. Otherwise they follow `core_out` and `core_oe`.
- R6: When the synchronized request returns high in standby, `cmu_reset` falls at the next edge and an exit window of WINDOW_US*CYC_PER_US clocks begins. `stby_status` stays high throughout this window.
- R7: `stby_status` clears only at the edge after a cycle in which the exit window has elapsed and `pll_lock` is high. Lock seen during the window has no effect on its length.
- R8: If `pll_lock` stays low for LOCK_LIMIT_US*CYC_PER_US clocks after the exit window, `lock_timeout` rises and stays high. It clears when the block returns to normal operation.
- R9: A request released during the entry phase does not shorten it. Entry completes, and exit then begins on the following edge.
- R10: A request asserted again during the exit phase does not abort the exit. The block returns to normal operation for one cycle and then enters again.
- R11: After reset the block is in normal operation, with all retention controls inactive, `stby_status` low, `lock_timeout` low and held output values of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_req_n | input | 1 | Active-low standby request |
| pll_lock | input | 1 | Lock indication from the clock-management units |
| pad_in | input | IO_W | Values arriving from input pads |
| core_out | input | IO_W | Output data from core logic |
| core_oe | input | IO_W | Output enables from core logic |
| core_in | output | IO_W | Pad-to-core values, forced high in retention |
| pad_out | output | IO_W | Output data toward pads, frozen in retention |
| pad_oe | output | IO_W | Output enables toward pads, frozen in retention |
| hold_en | output | 1 | Register hold enable |
| clk_pad_en | output | 1 | Clock input pad enable (low gates the pads) |
| in_force | output | 1 | Force-high on pad-to-core inputs |
| out_freeze | output | 1 | Output data and enable freeze |
| ddr_pulldown | output | 1 | Weak pull-down request for double-data-rate outputs |
| cmu_reset | output | 1 | Reset to the clock-management units |
| stby_status | output | 1 | High from the start of entry until exit completes with lock |
| lock_timeout | output | 1 | Lock not seen within the limit after the exit window |

## Verification
The hardest situations to reach are the ones where the request changes against a transition already under way: a release in the middle of entry, and a new request during exit. The stimulus pulses the request pin for a few cycles inside the entry window and asserts it again while the exit is waiting for lock. A behavioural PLL in the bench drops lock while `cmu_reset` is high and regains it after a delay that each scenario chooses. With that delay the bench can place lock inside the window, after it, or never, and so reach the timeout path.

// File: rtl/stby_seq.sv
module stby_seq #(
  parameter int CYC_PER_US    = 8,
  parameter int WINDOW_US     = 250,
  parameter int LOCK_LIMIT_US = 100,
  parameter int IO_W          = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stby_req_n,
  input  logic            pll_lock,
  input  logic [IO_W-1:0] pad_in,
  input  logic [IO_W-1:0] core_out,
  input  logic [IO_W-1:0] core_oe,
  output logic [IO_W-1:0] core_in,
  output logic [IO_W-1:0] pad_out,
  output logic [IO_W-1:0] pad_oe,
  output logic            hold_en,
  output logic            clk_pad_en,
  output logic            in_force,
  output logic            out_freeze,
  output logic            ddr_pulldown,
  output logic            cmu_reset,
  output logic            stby_status,
  output logic            lock_timeout
);
  localparam int PRE_W  = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int US_MAX = (WINDOW_US > LOCK_LIMIT_US) ? WINDOW_US : LOCK_LIMIT_US;
  localparam int US_W   = $clog2(US_MAX + 1);

  typedef enum logic [1:0] {NORMAL, ENTERING, STANDBY, EXITING} st_t;

  st_t             st;
  logic            s1, s2, win_done, frozen;
  logic [PRE_W-1:0] pre, pre_nx;
  logic [US_W-1:0]  us, us_nx;
  logic [IO_W-1:0]  held_out, held_oe;
  logic            tick, win_end, lim_end;

  assign tick    = (pre == PRE_W'(CYC_PER_US - 1));
  assign win_end = tick && (us == US_W'(WINDOW_US - 1));
  assign lim_end = tick && (us == US_W'(LOCK_LIMIT_US - 1));
  assign pre_nx  = tick ? '0 : pre + 1'b1;
  assign us_nx   = tick ? us + 1'b1 : us;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      st <= NORMAL;
      pre <= '0;
      us <= '0;
      win_done <= 1'b0;
      lock_timeout <= 1'b0;
      held_out <= '0;
      held_oe <= '0;
    end else begin
      s1 <= stby_req_n;
      s2 <= s1;
      if (st == NORMAL) begin
        held_out <= core_out;
        held_oe  <= core_oe;
      end
      case (st)
        NORMAL: begin
          pre <= '0;
          us <= '0;
          win_done <= 1'b0;
          lock_timeout <= 1'b0;
          if (!s2) st <= ENTERING;
        end
        ENTERING: begin
          if (win_end) begin
            st <= STANDBY;
            pre <= '0;
            us <= '0;
          end else begin
            pre <= pre_nx;
            us <= us_nx;
          end
        end
        STANDBY: begin
          pre <= '0;
          us <= '0;
          if (s2) st <= EXITING;
        end
        EXITING: begin
          if (!win_done) begin
            if (win_end) begin
              win_done <= 1'b1;
              pre <= '0;
              us <= '0;
            end else begin
              pre <= pre_nx;
              us <= us_nx;
            end
          end else if (pll_lock) begin
            st <= NORMAL;
            lock_timeout <= 1'b0;
          end else if (!lock_timeout) begin
            if (lim_end) lock_timeout <= 1'b1;
            else begin
              pre <= pre_nx;
              us <= us_nx;
            end
          end
        end
        default: st <= NORMAL;
      endcase
    end
  end

  assign frozen       = (st != NORMAL);
  assign hold_en      = frozen;
  assign clk_pad_en   = !frozen;
  assign in_force     = frozen;
  assign out_freeze   = frozen;
  assign ddr_pulldown = frozen;
  assign stby_status  = frozen;
  assign cmu_reset    = (st == ENTERING) || (st == STANDBY);

  assign core_in = in_force ? '1 : pad_in;
  assign pad_out = out_freeze ? held_out : core_out;
  assign pad_oe  = out_freeze ? held_oe : core_oe;
endmodule

// File: rtl/stby_seq_chk.sv
module stby_seq_chk #(
  parameter int IO_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pll_lock,
  input logic [IO_W-1:0] core_in,
  input logic [IO_W-1:0] pad_out,
  input logic [IO_W-1:0] pad_oe,
  input logic            in_force,
  input logic            out_freeze,
  input logic            cmu_reset,
  input logic            stby_status,
  input logic            lock_timeout
);
  a_r2_cmu_within_status: assert property (@(posedge clk) disable iff (!rst_n)
    cmu_reset |-> stby_status);

  a_r2_entry_starts_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stby_status) |-> cmu_reset);

  a_r4_inputs_forced: assert property (@(posedge clk) disable iff (!rst_n)
    in_force |-> (core_in == '1));

  a_r5_outputs_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_freeze && $past(out_freeze)) |-> ($stable(pad_out) && $stable(pad_oe)));

  a_r6_exit_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmu_reset) |-> stby_status);

  a_r7_clear_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stby_status) |-> $past(pll_lock));

  a_r8_timeout_in_exit: assert property (@(posedge clk) disable iff (!rst_n)
    lock_timeout |-> (stby_status && !cmu_reset));
endmodule

bind stby_seq stby_seq_chk #(.IO_W(IO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .core_in(core_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .in_force(in_force),
  .out_freeze(out_freeze), .cmu_reset(cmu_reset),
  .stby_status(stby_status), .lock_timeout(lock_timeout)
);

// File: tb/stby_seq_test.sv
module stby_seq_test;
  localparam int CPU = 3, WUS = 4, LUS = 5, W = 4;
  localparam int WIN = CPU * WUS, LIM = CPU * LUS;

  logic clk = 1'b0, rst_n = 1'b0, stby_req_n = 1'b1, pll_lock = 1'b1;
  logic [W-1:0] pad_in = '0, core_out = '0, core_oe = '0;
  logic [W-1:0] core_in, pad_out, pad_oe;
  logic hold_en, clk_pad_en, in_force, out_freeze, ddr_pulldown, cmu_reset, stby_status, lock_timeout;

  int n_chk = 0, n_fail = 0;
  int lock_after = 2, lock_cnt = 0;
  bit seen_to = 0;

  always #4 clk = ~clk;

  stby_seq #(.CYC_PER_US(CPU), .WINDOW_US(WUS), .LOCK_LIMIT_US(LUS), .IO_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .stby_req_n(stby_req_n), .pll_lock(pll_lock),
    .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .core_in(core_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .hold_en(hold_en), .clk_pad_en(clk_pad_en), .in_force(in_force),
    .out_freeze(out_freeze), .ddr_pulldown(ddr_pulldown), .cmu_reset(cmu_reset),
    .stby_status(stby_status), .lock_timeout(lock_timeout));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 normal, 1 entry, 2 standby, 3 exit window, 4 wait lock
  int ph = 0, el = 0;
  bit to = 0;
  logic q[$] = '{1'b1, 1'b1};
  logic [W-1:0] m_out = '0, m_oe = '0;

  always @(posedge clk or negedge rst_n) begin
    logic r;
    if (!rst_n) begin
      ph = 0; el = 0; to = 0; m_out = '0; m_oe = '0;
      q = '{1'b1, 1'b1};
    end else begin
      r = q.pop_front();
      q.push_back(stby_req_n);
      if (ph == 0) begin m_out = core_out; m_oe = core_oe; end
      case (ph)
        0: if (!r) begin ph = 1; el = 0; end
        1: begin el++; if (el == WIN) ph = 2; end
        2: if (r) begin ph = 3; el = 0; end
        3: begin el++; if (el == WIN) begin ph = 4; el = 0; end end
        default: if (pll_lock) begin ph = 0; to = 0; end
                 else if (!to) begin el++; if (el == LIM) to = 1; end
      endcase
    end
  end

  always @(negedge clk) begin
    bit fz;
    fz = (ph != 0);
    chk("R2 cmu_reset", cmu_reset, (ph == 1 || ph == 2));
    chk("R6/R7 status", stby_status, fz);
    chk("R3 controls", {hold_en, clk_pad_en, in_force, out_freeze, ddr_pulldown},
        {fz, !fz, fz, fz, fz});
    chk("R4 core_in", core_in, fz ? {W{1'b1}} : pad_in);
    chk("R5 pad_out", pad_out, fz ? m_out : core_out);
    chk("R5 pad_oe", pad_oe, fz ? m_oe : core_oe);
    chk("R8 timeout", lock_timeout, to);
    if (lock_timeout) seen_to = 1;
  end

  // PLL model: loses lock in reset, regains it lock_after cycles later (-1 = never)
  always @(negedge clk) begin
    #2;
    if (cmu_reset) begin pll_lock = 1'b0; lock_cnt = 0; end
    else if (!pll_lock && lock_after >= 0) begin
      lock_cnt++;
      if (lock_cnt >= lock_after) pll_lock = 1'b1;
    end
  end

  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk); #1;
      pad_in = W'($urandom); core_out = W'($urandom); core_oe = W'($urandom);
    end
  endtask

  task automatic wait_status(bit v);
    int k = 0;
    while (stby_status !== v && k < 400) begin @(negedge clk); k++; end
    #1;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #10000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int hi;
    cyc(3);
    @(negedge clk);
    chk("R11 reset status", {stby_status, lock_timeout, cmu_reset, clk_pad_en}, 4'b0001);
    chk("R11 reset pad_oe", pad_oe, core_oe);
    #1 rst_n = 1'b1;
    cyc(8);

    // R1: latency through the synchronizer; R7 lock during window ignored
    lock_after = 3;
    @(negedge clk); #1 stby_req_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 not yet", stby_status, 1'b0);
    @(negedge clk);
    chk("R1 entered", stby_status, 1'b1);
    cyc(WIN + 10);
    #1 stby_req_n = 1'b1;
    wait_status(1'b0);
    cyc(5);

    // R7: lock arrives well after the window
    lock_after = WIN + 6;
    #1 stby_req_n = 1'b0;
    cyc(WIN + 4);
    #1 stby_req_n = 1'b1;
    wait_status(1'b0);
    cyc(4);

    // R8: lock never arrives, then arrives late
    lock_after = -1; seen_to = 0;
    #1 stby_req_n = 1'b0;
    cyc(WIN + 3);
    #1 stby_req_n = 1'b1;
    cyc(WIN + LIM + 10);
    chk("R8 timeout raised", seen_to, 1'b1);
    lock_after = 0;
    wait_status(1'b0);
    @(negedge clk);
    chk("R8 timeout cleared", lock_timeout, 1'b0);
    cyc(4);

    // R9: release inside the entry window
    lock_after = 2;
    #1 stby_req_n = 1'b0;
    cyc(4);
    #1 stby_req_n = 1'b1;
    wait_status(1'b1);
    hi = 0;
    while (stby_status && hi < 400) begin @(negedge clk); hi++; end
    chk("R9 full entry then exit", (hi >= 2 * WIN), 1'b1);
    cyc(4);

    // R10: new request during exit
    lock_after = 2;
    #1 stby_req_n = 1'b0;
    cyc(WIN + 3);
    #1 stby_req_n = 1'b1;
    cyc(6);
    #1 stby_req_n = 1'b0;
    wait_status(1'b0);
    hi = 0;
    while (!stby_status && hi < 20) begin @(negedge clk); hi++; end
    chk("R10 one normal cycle", hi, 1);
    cyc(WIN + 3);
    #1 stby_req_n = 1'b1;
    wait_status(1'b0);
    cyc(6);
    report();
  end
endmodule